// File: doc/BRIEF.md
# Priority Interrupt Controller with Nesting Stack

This block gathers a parameterised number of interrupt sources and presents a single request line to a processor. Each source owns a pending flag, an enable bit and a programmable priority. A flag is set by a one-cycle hardware event pulse or by a register write, and only a register write clears it. A source takes part in arbitration when its flag and enable are both set and its priority is strictly above the current priority level. Among those sources, the highest priority wins. Equal priorities go to the lowest source index.

The winner is captured in a register, which drives the request line and the vector output. The captured winner is held until the processor acknowledges it. There is no spurious vector: if the source drops its flag or enable after capture, the request stays up and the acknowledge still returns that source's number.

On acknowledge, the current level is pushed onto a small last-in-first-out stack and the captured priority becomes the new level. An end-of-interrupt write pops the stack to restore the previous level, so higher-priority handlers can nest. Software reaches the block through a simple register write port and a combinational read port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The request line rises only when an enabled, flagged source has a priority strictly greater than the current level. A priority equal to the level never interrupts.
- R2: A source with priority 0 never interrupts. A current level of 15 blocks every source.
- R3: The highest priority wins. When priorities tie, the lowest source index wins.
- R4: The request line and the vector appear at the clock edge after the source state that caused them. Both stay fixed until acknowledge, even if the winning source clears its flag or enable in the meantime.
- R5: Acknowledge while the request is high has three effects at the next edge: the request drops, the current level becomes the captured source's priority, and the earlier level is pushed. Acknowledge while the request is low is ignored.
- R6: The stack holds 8 levels. An end-of-interrupt write pops the newest level into the current level. The pop is ignored when the stack is empty. A push onto a full stack is not stored, but the current level is still loaded.
- R7: Clearing a source's enable removes it from arbitration in the same way as clearing its flag. Setting the enable while the flag is already set raises a request just as a new event would.
- R8: Register map with 6-bit data:
  - Address i, for i below the source count, is source i's configuration: bits 3:0 priority, bit 4 enable, bit 5 flag.
  - Address equal to the source count holds the current level in bits 3:0, readable and writable.
  - The next address is the end-of-interrupt trigger and reads 0.
  - Other addresses read 0 and ignore writes.
  - A hardware event in the same cycle as a write that clears the flag leaves the flag set.
- R9: After reset all flags, enables and priorities are 0, the current level is 15, the stack is empty and the request line is low.
- R10: An acknowledge in the same cycle as an end-of-interrupt write or a current-level write is processed, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NUM_SRC | One-cycle event pulses that set source flags |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | AW | Register write address |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | AW | Register read address |
| reg_rdata | output | DW | Register read data (combinational) |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Interrupt acknowledge from the processor |
| cpu_vec | output | IDX_W | Source number of the captured winner |

## Verification
The assertions assume that `cpu_ack` is sampled as a level on each edge and may come at any time, including while no request is pending. They also assume that register writes and acknowledges can collide freely; no handshake ordering between the two sides is relied on.

The stimulus first walks through directed sequences:
- a source dropping its request after capture;
- equal-priority ties;
- stack overflow and underflow;
- acknowledge colliding with an end-of-interrupt write;
- a flag-clearing write colliding with an event.

It then runs a long random phase. In that phase the acknowledge, the events and the writes to every valid and invalid address are drawn independently, and the outputs are compared each cycle against a behavioural model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // Index width for a count of items, never below one bit.
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Smallest power of two that is at least n.
   function automatic int ceil_pow2(input int n);
      return 1 << idx_bits(n);
   endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 4,
   parameter int AW      = 4,
   parameter int DW      = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_SRC-1:0]                evt_i,
   input  logic                              wr_i,
   input  logic [AW-1:0]                     waddr_i,
   input  logic [DW-1:0]                     wdata_i,
   output logic [NUM_SRC-1:0]                flag_o,
   output logic [NUM_SRC-1:0]                en_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o
);
   localparam int EN_BIT   = PRIO_W;
   localparam int FLAG_BIT = PRIO_W + 1;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic sel;
      assign sel = wr_i && (waddr_i == AW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[i] <= 1'b0;
            en_o[i]   <= 1'b0;
            prio_o[i] <= '0;
         end else if (sel) begin
            prio_o[i] <= wdata_i[PRIO_W-1:0];
            en_o[i]   <= wdata_i[EN_BIT];
            flag_o[i] <= wdata_i[FLAG_BIT] | evt_i[i];
         end else if (evt_i[i]) begin
            flag_o[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 4,
   localparam int IDX_W  = idx_bits(NUM_SRC),
   localparam int LEAVES = ceil_pow2(NUM_SRC),
   localparam int NODES  = 2 * LEAVES - 1
) (
   input  logic [NUM_SRC-1:0]             req_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           any_o,
   output logic [IDX_W-1:0]               idx_o,
   output logic [PRIO_W-1:0]              prio_o
);
   logic              nv [NODES];
   logic [PRIO_W-1:0] np [NODES];
   logic [IDX_W-1:0]  ni [NODES];

   // Leaves: real sources, then padding that never requests.
   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < NUM_SRC) begin : g_real
         assign nv[LEAVES-1+j] = req_i[j];
         assign np[LEAVES-1+j] = prio_i[j];
      end else begin : g_pad
         assign nv[LEAVES-1+j] = 1'b0;
         assign np[LEAVES-1+j] = '0;
      end
      assign ni[LEAVES-1+j] = IDX_W'(j);
   end

   // Internal nodes: the left (lower index) child keeps ties.
   for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
      logic take_l;
      assign take_l = nv[2*k+1] & (~nv[2*k+2] | (np[2*k+1] >= np[2*k+2]));
      assign nv[k]  = nv[2*k+1] | nv[2*k+2];
      assign np[k]  = take_l ? np[2*k+1] : np[2*k+2];
      assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
   end

   assign any_o  = nv[0];
   assign idx_o  = ni[0];
   assign prio_o = np[0];
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
   parameter int PRIO_W = 4,
   parameter int DEPTH  = 8,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_val_i,
   input  logic              pop_i,
   input  logic              set_i,
   input  logic [PRIO_W-1:0] set_val_i,
   output logic [PRIO_W-1:0] cur_o,
   output logic [LVL_W-1:0]  level_o
);
   logic [PRIO_W-1:0] mem [DEPTH];
   logic [LVL_W-1:0]  lvl_m1;
   logic              full, empty;

   assign lvl_m1 = level_o - LVL_W'(1);
   assign full   = (level_o == LVL_W'(DEPTH));
   assign empty  = (level_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_o   <= '1;
         level_o <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push_i) begin
         cur_o <= push_val_i;
         if (!full) begin
            mem[level_o[PTR_W-1:0]] <= cur_o;
            level_o <= level_o + LVL_W'(1);
         end
      end else if (pop_i && !empty) begin
         cur_o   <= mem[lvl_m1[PTR_W-1:0]];
         level_o <= lvl_m1;
      end else if (set_i) begin
         cur_o <= set_val_i;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC     = 8,
   parameter int PRIO_W      = 4,
   parameter int STACK_DEPTH = 8,
   localparam int IDX_W = idx_bits(NUM_SRC),
   localparam int AW    = $clog2(NUM_SRC + 2),
   localparam int DW    = PRIO_W + 2,
   localparam int LVL_W = $clog2(STACK_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               reg_wr,
   input  logic [AW-1:0]      reg_waddr,
   input  logic [DW-1:0]      reg_wdata,
   input  logic [AW-1:0]      reg_raddr,
   output logic [DW-1:0]      reg_rdata,
   output logic               cpu_irq,
   input  logic               cpu_ack,
   output logic [IDX_W-1:0]   cpu_vec
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_prio_ctrl: NUM_SRC must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("irq_prio_ctrl: PRIO_W must be at least 1");
   end
   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("irq_prio_ctrl: STACK_DEPTH must be at least 2");
   end

   localparam logic [AW-1:0] CUR_ADDR = AW'(NUM_SRC);
   localparam logic [AW-1:0] EOI_ADDR = AW'(NUM_SRC + 1);

   logic [NUM_SRC-1:0]             flag, en, elig;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
   logic [PRIO_W-1:0]              cur_prio;
   logic [LVL_W-1:0]               stack_lvl;
   logic                           arb_any;
   logic [IDX_W-1:0]               arb_idx;
   logic [PRIO_W-1:0]              arb_prio;
   logic                           win_vld;
   logic [IDX_W-1:0]               win_idx;
   logic [PRIO_W-1:0]              win_prio;
   logic                           ack_ok, eoi_req, cur_wr;

   irq_src_bank #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .AW(AW), .DW(DW)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(src_evt),
      .wr_i(reg_wr), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
      .flag_o(flag), .en_o(en), .prio_o(prio)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = flag[i] & en[i] & (prio[i] > cur_prio);
   end

   irq_arb_tree #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
   ) u_arb (
      .req_i(elig), .prio_i(prio),
      .any_o(arb_any), .idx_o(arb_idx), .prio_o(arb_prio)
   );

   // Captured winner: held until acknowledge, never withdrawn.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_vld  <= 1'b0;
         win_idx  <= '0;
         win_prio <= '0;
      end else if (ack_ok) begin
         win_vld <= 1'b0;
      end else if (!win_vld && arb_any) begin
         win_vld  <= 1'b1;
         win_idx  <= arb_idx;
         win_prio <= arb_prio;
      end
   end

   assign ack_ok  = cpu_ack & win_vld;
   assign eoi_req = reg_wr && (reg_waddr == EOI_ADDR);
   assign cur_wr  = reg_wr && (reg_waddr == CUR_ADDR);

   irq_prio_stack #(
      .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)
   ) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push_i(ack_ok), .push_val_i(win_prio),
      .pop_i(eoi_req && !ack_ok),
      .set_i(cur_wr && !ack_ok), .set_val_i(reg_wdata[PRIO_W-1:0]),
      .cur_o(cur_prio), .level_o(stack_lvl)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (reg_raddr == AW'(i)) reg_rdata = {flag[i], en[i], prio[i]};
      end
      if (reg_raddr == CUR_ADDR) reg_rdata = DW'(cur_prio);
   end

   assign cpu_irq = win_vld;
   assign cpu_vec = win_idx;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 3,
   parameter int LVL_W  = 4,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_irq,
   input logic              cpu_ack,
   input logic [IDX_W-1:0]  cpu_vec,
   input logic [PRIO_W-1:0] cur,
   input logic [PRIO_W-1:0] win_p,
   input logic [LVL_W-1:0]  level,
   input logic              eoi
);
   AST_IRQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq) |-> (win_p > $past(cur)));                        // R1
   AST_NO_ZERO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (win_p != '0));                                      // R2
   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(cpu_vec)));        // R4
   AST_ACK_LOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && cpu_ack) |=> (!cpu_irq && cur == $past(win_p)));     // R5
   AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));                                         // R6
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && cpu_ack && level < LVL_W'(DEPTH))
         |=> (level == $past(level) + LVL_W'(1)));                     // R6
   AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !(cpu_irq && cpu_ack) && level == '0) |=> $stable(cur)); // R6
   AST_EOI_LOST_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && cpu_irq && cpu_ack && level < LVL_W'(DEPTH))
         |=> (level != '0));                                           // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .PRIO_W(PRIO_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .DEPTH(STACK_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
   .cpu_vec(cpu_vec), .cur(cur_prio), .win_p(win_prio),
   .level(stack_lvl), .eoi(eoi_req)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
   localparam int N = 8, DEPTH = 8, AW = 4, DW = 6, IW = 3;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0]  hw_evt = '0;
   logic          wr_en = 1'b0, iack = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          irq;
   logic [IW-1:0] vec;

   int    n_chk = 0, n_fail = 0;
   bit    go = 1'b0, done = 1'b0;
   string phase = "R9";

   always #2 clk = ~clk;

   irq_prio_ctrl #(.NUM_SRC(N), .PRIO_W(4), .STACK_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .src_evt(hw_evt),
      .reg_wr(wr_en), .reg_waddr(wr_addr), .reg_wdata(wr_data),
      .reg_raddr(rd_addr), .reg_rdata(rd_data),
      .cpu_irq(irq), .cpu_ack(iack), .cpu_vec(vec)
   );

   // Behavioural reference model
   bit m_flag[N], m_en[N], m_wv;
   int m_prio[N], m_cur, m_wi, m_wp;
   int m_stk[$];

   always @(posedge clk) begin
      int bi, bp;
      bit ackd;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
         m_cur = 15; m_stk.delete(); m_wv = 0; m_wi = 0; m_wp = 0;
      end else begin
         bi = -1; bp = 0;
         ackd = iack && m_wv;
         for (int i = 0; i < N; i++)
            if (m_flag[i] && m_en[i] && m_prio[i] > m_cur && (bi < 0 || m_prio[i] > bp)) begin
               bi = i; bp = m_prio[i];
            end
         if (ackd) begin
            if (m_stk.size() < DEPTH) m_stk.push_back(m_cur);
            m_cur = m_wp;
            m_wv = 0;
         end else begin
            if (wr_en && wr_addr == N + 1 && m_stk.size() > 0) m_cur = m_stk.pop_back();
            else if (wr_en && wr_addr == N) m_cur = int'(wr_data[3:0]);
            if (!m_wv && bi >= 0) begin m_wv = 1; m_wi = bi; m_wp = bp; end
         end
         for (int i = 0; i < N; i++) begin
            if (wr_en && wr_addr == i) begin
               m_prio[i] = int'(wr_data[3:0]); m_en[i] = wr_data[4]; m_flag[i] = wr_data[5];
            end
            if (hw_evt[i]) m_flag[i] = 1;
         end
      end
   end

   function automatic int exp_rd(input int a);
      if (a < N) return (int'(m_flag[a]) << 5) | (int'(m_en[a]) << 4) | m_prio[a];
      if (a == N) return m_cur;
      return 0;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && go) begin
         chk(phase, "irq", int'(irq), int'(m_wv));
         if (m_wv) chk(phase, "vector", int'(vec), m_wi);
         chk(phase, "read data", int'(rd_data), exp_rd(int'(rd_addr)));
      end
   end

   function automatic logic [DW-1:0] cfg(input bit f, input bit e, input int p);
      return {f, e, p[3:0]};
   endfunction

   task automatic tick();
      @(negedge clk); #1;
   endtask
   task automatic idle(input int n);
      repeat (n) tick();
   endtask
   task automatic wr(input int a, input logic [DW-1:0] d);
      tick(); wr_en = 1; wr_addr = AW'(a); wr_data = d;
      tick(); wr_en = 0;
   endtask
   task automatic ack();
      tick(); iack = 1;
      tick(); iack = 0;
   endtask
   task automatic evt(input logic [N-1:0] m);
      tick(); hw_evt = m;
      tick(); hw_evt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; go = 1;

      // R9: reset state
      phase = "R9";
      rd_addr = AW'(N); tick();
      chk("R9", "current level", int'(rd_data), 15);
      chk("R9", "irq", int'(irq), 0);
      rd_addr = 0; tick();
      chk("R9", "source 0 config", int'(rd_data), 0);

      // R2: priority 0 and level 15
      phase = "R2";
      wr(0, cfg(1, 1, 0)); wr(N, 0); idle(3);
      chk("R2", "irq with prio 0", int'(irq), 0);
      wr(N, 15); wr(1, cfg(1, 1, 15)); idle(3);
      chk("R2", "irq at level 15", int'(irq), 0);

      // R1: strict comparison
      phase = "R1";
      wr(1, cfg(1, 1, 5)); wr(N, 5); idle(3);
      chk("R1", "irq at equal level", int'(irq), 0);
      wr(N, 4); idle(3);
      chk("R1", "irq above level", int'(irq), 1);
      chk("R1", "vector", int'(vec), 1);

      // R4: source negates after capture
      phase = "R4";
      wr(1, cfg(0, 1, 5)); idle(3);
      chk("R4", "irq held", int'(irq), 1);
      chk("R4", "vector held", int'(vec), 1);
      wr(1, cfg(0, 0, 5)); idle(2);
      ack(); idle(2);
      chk("R5", "irq after ack", int'(irq), 0);
      rd_addr = AW'(N); tick();
      chk("R5", "level after ack", int'(rd_data), 5);

      // R3: tie breaking
      phase = "R3";
      wr(2, cfg(0, 1, 9)); wr(3, cfg(0, 1, 9)); wr(5, cfg(0, 1, 7));
      evt(8'b0010_1100); idle(2);
      chk("R3", "tie winner", int'(vec), 2);
      ack(); idle(1);
      phase = "R5";
      ack(); idle(1);
      chk("R5", "idle ack ignored level", int'(rd_data), 9);
      phase = "R6";
      wr(2, cfg(0, 1, 9));
      wr(N + 1, 0); idle(2);
      chk("R6", "vector after pop", int'(vec), 3);

      // R7: enable acts like flag
      phase = "R7";
      wr(3, cfg(1, 0, 9)); ack(); idle(1);
      wr(N + 1, 0); idle(2);
      chk("R7", "disabled source skipped", int'(vec), 5);
      ack(); wr(5, cfg(1, 0, 7)); wr(N + 1, 0); idle(3);
      chk("R7", "no irq with enables cleared", int'(irq), 0);
      wr(3, cfg(1, 1, 9)); idle(2);
      chk("R7", "enable with flag set", int'(irq), 1);
      chk("R7", "vector", int'(vec), 3);
      ack();

      // R10: ack collides with end-of-interrupt
      phase = "R10";
      wr(5, cfg(1, 1, 12)); idle(2);
      tick(); iack = 1; wr_en = 1; wr_addr = AW'(N + 1); wr_data = '0;
      tick(); iack = 0; wr_en = 0;
      chk("R10", "level after collision", int'(rd_data), 12);

      // R6: drain, overflow, underflow
      phase = "R6";
      for (int i = 0; i < N; i++) wr(i, 0);
      idle(1);
      if (irq) ack();
      repeat (10) wr(N + 1, 0);
      wr(N, 0);
      for (int k = 1; k <= 10; k++) begin
         wr((k - 1) % N, cfg(1, 1, k)); idle(2);
         ack(); wr((k - 1) % N, 0);
      end
      chk("R6", "level after nesting", int'(rd_data), 10);
      repeat (10) wr(N + 1, 0);
      idle(1);
      chk("R6", "level after underflow", int'(rd_data), 0);

      // R8: register map and event/write collision
      phase = "R8";
      tick(); hw_evt = 8'h10; wr_en = 1; wr_addr = 4; wr_data = cfg(0, 0, 3);
      tick(); hw_evt = '0; wr_en = 0;
      rd_addr = 4; tick();
      chk("R8", "event beats clearing write", int'(rd_data), 6'b10_0011);
      rd_addr = AW'(N + 1); tick();
      chk("R8", "eoi reads zero", int'(rd_data), 0);
      wr(12, 6'h3f); rd_addr = 12; tick();
      chk("R8", "unused address", int'(rd_data), 0);

      // R5: random traffic against the model
      phase = "R5";
      for (int c = 0; c < 4000; c++) begin
         tick();
         hw_evt  = (($urandom % 4) == 0) ? N'($urandom) : '0;
         wr_en   = (($urandom % 3) == 0);
         wr_addr = AW'($urandom % (N + 3));
         wr_data = DW'($urandom);
         iack    = (($urandom % 4) == 0);
         rd_addr = AW'($urandom % (N + 3));
      end
      tick(); hw_evt = '0; wr_en = 0; iack = 0;
      idle(2);

      go = 0; done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule